// File: doc/BRIEF.md
# Wide Initiator Block-Move Engine

This block carries out a single block-move instruction for a 16-bit parallel storage bus on which the chip acts as initiator. An instruction supplies an opcode bit, the bus phase the move expects, a byte count and a start address. When the instruction is started, the engine waits for a target request that has not yet been acknowledged. It then captures the phase lines and the data lanes, and compares the captured phase with the instruction. Bytes move only when the two phases are equal. Bytes travel between the bus and a byte-wide memory port that has one cycle of read latency. Each bus word is closed with a request/acknowledge handshake.

The opcode bit selects one of two variants. The plain move (opcode 1) always ends cleanly: an odd count finishes with a single-byte transfer on the low lane. The chained move (opcode 0) is meant for transfers split over several instructions. When such a move ends on an odd byte, the spare byte is kept in a holder and merged into the next instruction of the same direction, so bus words stay full. A one-cycle completion pulse reports the remaining count, the final address, a phase-mismatch flag and whether a byte is being held.

Top module: `bmv_engine`

## Requirements
- R1: A start request while `link_up_i` is low is ignored: the engine stays idle, gives no acknowledge and gives no completion pulse.
- R2: The engine captures the phase lines on the first request seen while its acknowledge is low, and shows that value on `phase_o`.
- R3: If the captured phase differs from `exp_phase_i`, the engine gives a completion pulse with `mismatch_o` high. The remaining count equals the instruction count, the end address equals the start address, and no acknowledge is given.
- R4: On a phase match, exactly `count_i` bytes are moved. The address advances once per byte. The completion pulse reports a remaining count of 0 and an end address of start plus count.
- R5: Phase bit 0 set to 1 means receive (bus to memory) and 0 means send (memory to bus). Within a bus word, the low lane `[7:0]` carries the lower-addressed byte and the high lane `[15:8]` carries the next byte. The memory port writes only during a receive.
- R6: For each word, the acknowledge rises after the data is valid. It stays high while the request is high and falls in the cycle after the request goes low. `bus_data_oe_o` is high during a send acknowledge.
- R7: A plain move with an odd count ends with a single-byte word: on send the last byte is on the low lane and the high lane is 0; on receive only the low lane is stored. No byte is held afterwards.
- R8: A chained receive that ends on an odd byte stores the high lane of its last word in the holder and sets `resid_valid_o`. The next receive writes the held byte at its own start address first. That byte takes one count and uses no bus handshake.
- R9: A chained send that ends on an odd byte reads the last byte into the holder without sending it. The next send's first word carries the held byte on the low lane and its own first byte on the high lane, and that word uses one count.
- R10: A held byte is dropped when the next phase-matched move with a nonzero count runs in the opposite direction.
- R11: The completion pulse `done_o` lasts exactly one cycle.
- R12: A phase-matched instruction with a count of 0 completes with no acknowledge and no memory access, and leaves the holder as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up_i | input | 1 | High while connected to the bus as initiator |
| start_i | input | 1 | Starts the instruction presented on the instruction inputs |
| op_plain_i | input | 1 | Opcode bit: 1 plain move, 0 chained move |
| exp_phase_i | input | 3 | Phase the instruction expects |
| count_i | input | CW | Byte count |
| addr_i | input | AW | Start address |
| bus_req_i | input | 1 | Target request |
| bus_phase_i | input | 3 | Bus phase lines |
| bus_data_i | input | 16 | Bus data from the target |
| bus_ack_o | output | 1 | Initiator acknowledge |
| bus_data_o | output | 16 | Bus data to the target |
| bus_data_oe_o | output | 1 | Bus data drive enable |
| mem_addr_o | output | AW | Memory byte address |
| mem_rd_o | output | 1 | Memory read strobe (data returns one cycle later) |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |
| done_o | output | 1 | Completion pulse |
| mismatch_o | output | 1 | Phase mismatch, valid with `done_o` |
| remain_o | output | CW | Remaining count, valid with `done_o` |
| end_addr_o | output | AW | Final address, valid with `done_o` |
| resid_valid_o | output | 1 | A byte is held for the next instruction |
| phase_o | output | 3 | Last captured phase |

## Verification
The acknowledge assertions assume a well-behaved target. Such a target keeps its request high until it sees the acknowledge, and raises a new request only after the acknowledge has fallen. The bench target model is a per-cycle state machine that follows this order, and it drops a request left pending when its instruction ends. The holder assertion assumes that the count never underflows and that a held byte is always consumed or dropped before a new one is loaded. The stimulus respects this by holding the count and the direction stable for the length of each instruction. Phases are driven stable for as long as a request is high.

// File: rtl/bmv_pkg.sv
package bmv_pkg;
  localparam int BYTE_W  = 8;
  localparam int PHASE_W = 3;
  localparam int WORD_W  = 2 * BYTE_W;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_CHECK, S_RX_RES, S_RX_LO, S_RX_HI,
    S_TX_RL, S_TX_GL, S_TX_RH, S_TX_GH, S_ACK, S_DONE
  } bmv_state_e;

  function automatic logic phase_is_rx(input logic [PHASE_W-1:0] ph);
    return ph[0];
  endfunction
endpackage

// File: rtl/bmv_cursor.sv
module bmv_cursor #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      cnt_q  <= cnt_i;
    end else if (step_i) begin
      addr_q <= addr_q + AW'(1);
      cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;

  // R4: the sequencer never steps past the end of the count
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    step_i |-> cnt_q != '0);
endmodule

// File: rtl/bmv_holder.sv
module bmv_holder #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [BW-1:0] byte_i,
  input  logic          rx_i,
  input  logic          clr_i,
  output logic          valid_o,
  output logic [BW-1:0] byte_o,
  output logic          rx_o
);
  logic          valid_q;
  logic [BW-1:0] byte_q;
  logic          rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      byte_q  <= '0;
      rx_q    <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      byte_q  <= byte_i;
      rx_q    <= rx_i;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign byte_o  = byte_q;
  assign rx_o    = rx_q;

  // R8: a held byte is always consumed or dropped before a new one lands
  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !valid_q);
endmodule

// File: rtl/bmv_req_latch.sv
module bmv_req_latch #(
  parameter int PW = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_i,
  input  logic [PW-1:0] phase_i,
  input  logic [DW-1:0] data_i,
  output logic [PW-1:0] phase_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= '0;
      data_o  <= '0;
    end else if (cap_i) begin
      phase_o <= phase_i;
      data_o  <= data_i;
    end
  end
endmodule

// File: rtl/bmv_engine.sv
module bmv_engine
  import bmv_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               link_up_i,
  input  logic               start_i,
  input  logic               op_plain_i,
  input  logic [PHASE_W-1:0] exp_phase_i,
  input  logic [CW-1:0]      count_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               bus_req_i,
  input  logic [PHASE_W-1:0] bus_phase_i,
  input  logic [WORD_W-1:0]  bus_data_i,
  output logic               bus_ack_o,
  output logic [WORD_W-1:0]  bus_data_o,
  output logic               bus_data_oe_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [BYTE_W-1:0]  mem_wdata_o,
  input  logic [BYTE_W-1:0]  mem_rdata_i,
  output logic               done_o,
  output logic               mismatch_o,
  output logic [CW-1:0]      remain_o,
  output logic [AW-1:0]      end_addr_o,
  output logic               resid_valid_o,
  output logic [PHASE_W-1:0] phase_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  bmv_state_e st, nxt;
  logic op_q, first_q, mis_q, dir_rx_q;
  logic [PHASE_W-1:0] exp_q;
  logic [BYTE_W-1:0]  txlo_q, txhi_q;

  logic cap, cur_load, cur_step, h_load, h_clr, h_load_rx;
  logic [BYTE_W-1:0] h_load_byte;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cur_cnt;
  logic h_valid, h_rx;
  logic [BYTE_W-1:0] h_byte;
  logic [PHASE_W-1:0] ph_q;
  logic [WORD_W-1:0]  rxd_q;
  logic go, ph_ok, merge;

  bmv_req_latch #(.PW(PHASE_W), .DW(WORD_W)) u_latch (
    .clk(clk), .rst(rst), .cap_i(cap), .phase_i(bus_phase_i), .data_i(bus_data_i),
    .phase_o(ph_q), .data_o(rxd_q));

  bmv_cursor #(.AW(AW), .CW(CW)) u_cursor (
    .clk(clk), .rst(rst), .load_i(cur_load), .addr_i(addr_i), .cnt_i(count_i),
    .step_i(cur_step), .addr_o(cur_addr), .cnt_o(cur_cnt));

  bmv_holder #(.BW(BYTE_W)) u_holder (
    .clk(clk), .rst(rst), .load_i(h_load), .byte_i(h_load_byte), .rx_i(h_load_rx),
    .clr_i(h_clr), .valid_o(h_valid), .byte_o(h_byte), .rx_o(h_rx));

  assign go    = start_i && link_up_i;
  assign ph_ok = (ph_q == exp_q);
  assign merge = h_valid && !h_rx && !phase_is_rx(ph_q);

  always_comb begin
    nxt = st;
    cap = 1'b0; cur_load = 1'b0; cur_step = 1'b0;
    h_load = 1'b0; h_clr = 1'b0; h_load_rx = 1'b0; h_load_byte = '0;
    mem_rd_o = 1'b0; mem_wr_o = 1'b0; mem_wdata_o = '0;
    unique case (st)
      S_IDLE: if (go) begin cur_load = 1'b1; nxt = S_WAIT; end
      S_WAIT: if (bus_req_i && !bus_ack_o) begin
        cap = 1'b1;
        nxt = first_q ? S_CHECK : (dir_rx_q ? S_RX_LO : S_TX_RL);
      end
      S_CHECK: begin
        if (!ph_ok || cur_cnt == '0) nxt = S_DONE;
        else if (phase_is_rx(ph_q)) begin
          if (h_valid && h_rx) nxt = S_RX_RES;
          else begin h_clr = h_valid; nxt = S_RX_LO; end
        end else begin
          h_clr = h_valid;
          nxt = merge ? S_TX_RH : S_TX_RL;
        end
      end
      S_RX_RES: begin
        mem_wr_o = 1'b1; mem_wdata_o = h_byte; h_clr = 1'b1; cur_step = 1'b1;
        nxt = (cur_cnt == ONE) ? S_DONE : S_RX_LO;
      end
      S_RX_LO: begin
        mem_wr_o = 1'b1; mem_wdata_o = rxd_q[BYTE_W-1:0]; cur_step = 1'b1;
        if (cur_cnt == ONE) begin
          h_load = !op_q; h_load_rx = 1'b1; h_load_byte = rxd_q[WORD_W-1:BYTE_W];
          nxt = S_ACK;
        end else nxt = S_RX_HI;
      end
      S_RX_HI: begin
        mem_wr_o = 1'b1; mem_wdata_o = rxd_q[WORD_W-1:BYTE_W]; cur_step = 1'b1;
        nxt = S_ACK;
      end
      S_TX_RL: begin mem_rd_o = 1'b1; nxt = S_TX_GL; end
      S_TX_GL: begin
        cur_step = 1'b1;
        if (cur_cnt == ONE && !op_q) begin
          h_load = 1'b1; h_load_byte = mem_rdata_i; nxt = S_DONE;
        end else nxt = (cur_cnt == ONE) ? S_ACK : S_TX_RH;
      end
      S_TX_RH: begin mem_rd_o = 1'b1; nxt = S_TX_GH; end
      S_TX_GH: begin cur_step = 1'b1; nxt = S_ACK; end
      S_ACK: if (!bus_req_i) begin
        if (cur_cnt == '0) nxt = S_DONE;
        else if (!dir_rx_q && !op_q && cur_cnt == ONE) nxt = S_TX_RL;
        else nxt = S_WAIT;
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; op_q <= 1'b0; first_q <= 1'b0; mis_q <= 1'b0; dir_rx_q <= 1'b0;
      exp_q <= '0; txlo_q <= '0; txhi_q <= '0;
      done_o <= 1'b0; mismatch_o <= 1'b0; remain_o <= '0; end_addr_o <= '0;
    end else begin
      st <= nxt;
      done_o <= 1'b0;
      mismatch_o <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          op_q <= op_plain_i; exp_q <= exp_phase_i; first_q <= 1'b1; mis_q <= 1'b0;
        end
        S_CHECK: begin
          first_q <= 1'b0;
          dir_rx_q <= phase_is_rx(ph_q);
          if (!ph_ok) mis_q <= 1'b1;
          else if (merge) txlo_q <= h_byte;
        end
        S_TX_GL: begin txlo_q <= mem_rdata_i; txhi_q <= '0; end
        S_TX_GH: txhi_q <= mem_rdata_i;
        S_DONE: begin
          done_o <= 1'b1; mismatch_o <= mis_q; remain_o <= cur_cnt; end_addr_o <= cur_addr;
        end
        default: ;
      endcase
    end
  end

  assign bus_ack_o     = (st == S_ACK);
  assign bus_data_oe_o = (st == S_ACK) && !dir_rx_q;
  assign bus_data_o    = bus_data_oe_o ? {txhi_q, txlo_q} : '0;
  assign mem_addr_o    = cur_addr;
  assign resid_valid_o = h_valid;
  assign phase_o       = ph_q;

  // R1: without a link the engine does not leave idle
  p_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && start_i && !link_up_i) |=> st == S_IDLE);
  // R6: acknowledge is held while the request stays high
  p_ack_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_ack_o && bus_req_i) |=> bus_ack_o);
  // R6: acknowledge is released once the request has dropped
  p_ack_release_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_ack_o && !bus_req_i) |=> !bus_ack_o);
  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R5: memory writes only happen while receiving
  p_rx_write_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_o && st != S_RX_RES) |-> dir_rx_q);
endmodule

// File: tb/bmv_engine_tb_top.sv
`timescale 1ns/1ps
module bmv_engine_tb_top;
  logic clk = 1'b0;
  logic rst;
  always #5 clk = ~clk;

  logic link_up_i, start_i, op_plain_i;
  logic [2:0] exp_phase_i, bus_phase_i, phase_o;
  logic [7:0] count_i, addr_i, mem_addr_o, mem_wdata_o, remain_o, end_addr_o;
  logic [7:0] mem_rdata_i;
  logic bus_req_i, bus_ack_o, bus_data_oe_o, mem_rd_o, mem_wr_o;
  logic done_o, mismatch_o, resid_valid_o;
  logic [15:0] bus_data_i, bus_data_o;

  bmv_engine #(.AW(8), .CW(8)) dut_i (
    .clk(clk), .rst(rst), .link_up_i(link_up_i), .start_i(start_i),
    .op_plain_i(op_plain_i), .exp_phase_i(exp_phase_i), .count_i(count_i),
    .addr_i(addr_i), .bus_req_i(bus_req_i), .bus_phase_i(bus_phase_i),
    .bus_data_i(bus_data_i), .bus_ack_o(bus_ack_o), .bus_data_o(bus_data_o),
    .bus_data_oe_o(bus_data_oe_o), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .mismatch_o(mismatch_o), .remain_o(remain_o),
    .end_addr_o(end_addr_o), .resid_valid_o(resid_valid_o), .phase_o(phase_o));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model, one cycle read latency
  logic [7:0] mem [256];
  function automatic logic [7:0] pat(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(8'(i));
    end else begin
      if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
      if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
    end
  end

  // target model
  logic tgt_en = 1'b0;
  logic [2:0] tgt_phase = 3'b0;
  logic [7:0] tgt_seed = 8'h0;
  int nw = 0;
  logic [15:0] sent [16];
  logic sent_oe [16];
  initial begin
    bus_req_i = 1'b0; bus_phase_i = '0; bus_data_i = '0;
    forever begin
      @(negedge clk);
      if (!tgt_en) bus_req_i = 1'b0;
      else if (bus_req_i && bus_ack_o) begin
        sent[nw] = bus_data_o; sent_oe[nw] = bus_data_oe_o; nw++;
        bus_req_i = 1'b0;
      end else if (!bus_req_i && !bus_ack_o) begin
        bus_phase_i = tgt_phase;
        bus_data_i = {tgt_seed + 8'(2*nw + 1), tgt_seed + 8'(2*nw)};
        bus_req_i = 1'b1;
      end
    end
  end

  logic d_seen, d_mis, d_res;
  logic [7:0] d_rem, d_ead;
  logic [2:0] d_ph;
  task automatic run(input logic op, input logic [2:0] ep, input logic [2:0] bp,
                     input logic [7:0] c, input logic [7:0] a, input logic [7:0] s);
    int to;
    tgt_phase = bp; tgt_seed = s; nw = 0; tgt_en = 1'b1;
    op_plain_i = op; exp_phase_i = ep; count_i = c; addr_i = a; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    to = 0;
    while (!done_o && to < 2000) begin @(negedge clk); to++; end
    d_seen = done_o; d_mis = mismatch_o; d_rem = remain_o; d_ead = end_addr_o;
    @(negedge clk);
    d_res = resid_valid_o; d_ph = phase_o;
    chk(d_seen, "R11 done pulse seen", int'(d_seen), 1);
    chk(!done_o, "R11 done lasts one cycle", int'(done_o), 0);
    tgt_en = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  typedef struct packed {
    logic op; logic [2:0] ep; logic [2:0] bp; logic [7:0] cnt; logic [7:0] addr;
    logic mis; logic [7:0] rem; logic [7:0] ead; logic [3:0] nwd;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b1, 3'b001, 3'b001, 8'd6, 8'h10, 1'b0, 8'd0, 8'h16, 4'd3},
    '{1'b1, 3'b000, 3'b000, 8'd4, 8'h40, 1'b0, 8'd0, 8'h44, 4'd2},
    '{1'b1, 3'b001, 3'b001, 8'd5, 8'h20, 1'b0, 8'd0, 8'h25, 4'd3},
    '{1'b1, 3'b000, 3'b000, 8'd3, 8'h60, 1'b0, 8'd0, 8'h63, 4'd2},
    '{1'b0, 3'b001, 3'b001, 8'd8, 8'h80, 1'b0, 8'd0, 8'h88, 4'd4},
    '{1'b1, 3'b000, 3'b011, 8'd7, 8'h30, 1'b1, 8'd7, 8'h30, 4'd0},
    '{1'b0, 3'b001, 3'b000, 8'd2, 8'h70, 1'b1, 8'd2, 8'h70, 4'd0},
    '{1'b1, 3'b001, 3'b001, 8'd0, 8'h50, 1'b0, 8'd0, 8'h50, 4'd0}
  };

  bit wd_fired = 1'b0;
  initial begin
    #(200000 * 10);
    wd_fired = 1'b1;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s, held;
    rst = 1'b1; link_up_i = 1'b0; start_i = 1'b0; op_plain_i = 1'b0;
    exp_phase_i = '0; count_i = '0; addr_i = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(!bus_ack_o && !bus_data_oe_o, "reset ack/oe low", int'(bus_ack_o), 0);
    chk(!done_o && !resid_valid_o, "reset done/resid low", int'(resid_valid_o), 0);

    // R1: start with link down is ignored
    begin
      bit saw = 1'b0;
      tgt_en = 1'b1; tgt_phase = 3'b001; nw = 0;
      op_plain_i = 1'b1; exp_phase_i = 3'b001; count_i = 8'd4; addr_i = 8'hF0;
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      for (int i = 0; i < 20; i++) begin
        if (done_o || bus_ack_o) saw = 1'b1;
        @(negedge clk);
      end
      chk(!saw && nw == 0, "R1 no activity when link down", nw, 0);
      tgt_en = 1'b0; @(negedge clk); @(negedge clk);
    end
    link_up_i = 1'b1;

    // vector table
    for (int v = 0; v < 8; v++) begin
      vec_t t = VECS[v];
      s = 8'(v * 32 + 3);
      run(t.op, t.ep, t.bp, t.cnt, t.addr, s);
      chk(d_mis == t.mis, $sformatf("R3 mismatch flag v%0d", v), int'(d_mis), int'(t.mis));
      chk(d_rem == t.rem, $sformatf("R4 remaining v%0d", v), d_rem, t.rem);
      chk(d_ead == t.ead, $sformatf("R4 end address v%0d", v), d_ead, t.ead);
      chk(nw == int'(t.nwd), $sformatf("R6 word handshakes v%0d", v), nw, t.nwd);
      chk(d_ph == t.bp, $sformatf("R2 captured phase v%0d", v), d_ph, t.bp);
      chk(!d_res, $sformatf("R7 nothing held v%0d", v), int'(d_res), 0);
      if (!t.mis && t.bp[0]) begin
        for (int i = 0; i < int'(t.cnt); i++)
          chk(mem[t.addr + 8'(i)] == s + 8'(i), $sformatf("R5 rx byte v%0d i%0d", v, i),
              mem[t.addr + 8'(i)], s + 8'(i));
      end else if (!t.mis) begin
        for (int j = 0; j < int'(t.nwd); j++) begin
          logic [7:0] lo, hi;
          lo = pat(t.addr + 8'(2*j));
          hi = (2*j + 1 < int'(t.cnt)) ? pat(t.addr + 8'(2*j + 1)) : 8'h00;
          chk(sent[j] == {hi, lo}, $sformatf("R5 R7 tx word v%0d w%0d", v, j),
              sent[j], {hi, lo});
          chk(sent_oe[j], $sformatf("R6 drive enable v%0d w%0d", v, j), int'(sent_oe[j]), 1);
        end
      end
    end
    // R12 covered by v7 (count 0): zero words and address unchanged

    // R8: chained receive with odd end, then receive consuming residue
    run(1'b0, 3'b001, 3'b001, 8'd3, 8'h90, 8'h40);
    chk(d_res, "R8 residue held after odd chained rx", int'(d_res), 1);
    chk(nw == 2 && d_ead == 8'h93, "R8 rx words", nw, 2);
    for (int i = 0; i < 3; i++)
      chk(mem[8'h90 + 8'(i)] == 8'h40 + 8'(i), "R8 rx bytes first", mem[8'h90 + 8'(i)], 8'h40 + 8'(i));
    run(1'b0, 3'b001, 3'b001, 8'd4, 8'hA0, 8'h60);
    chk(mem[8'hA0] == 8'h43, "R8 residue written first", mem[8'hA0], 8'h43);
    for (int i = 0; i < 3; i++)
      chk(mem[8'hA1 + 8'(i)] == 8'h60 + 8'(i), "R8 bytes after residue", mem[8'hA1 + 8'(i)], 8'h60 + 8'(i));
    chk(nw == 2 && d_rem == 8'd0, "R8 residue used no handshake", nw, 2);
    chk(d_res, "R8 new residue held", int'(d_res), 1);

    // R10: opposite-direction move drops the held byte
    run(1'b1, 3'b000, 3'b000, 8'd2, 8'hE0, 8'h00);
    chk(!d_res, "R10 holder dropped", int'(d_res), 0);
    chk(nw == 1 && sent[0] == {pat(8'hE1), pat(8'hE0)}, "R10 normal word", sent[0], {pat(8'hE1), pat(8'hE0)});

    // R9: chained send odd end, merge into next sends
    run(1'b0, 3'b000, 3'b000, 8'd3, 8'hB0, 8'h00);
    held = pat(8'hB2);
    chk(nw == 1 && sent[0] == {pat(8'hB1), pat(8'hB0)}, "R9 first send word", sent[0], {pat(8'hB1), pat(8'hB0)});
    chk(d_res && d_ead == 8'hB3 && d_rem == 8'd0, "R9 byte held not sent", int'(d_res), 1);
    run(1'b0, 3'b000, 3'b000, 8'd2, 8'hC0, 8'h00);
    chk(nw == 1 && sent[0] == {pat(8'hC0), held}, "R9 merged word", sent[0], {pat(8'hC0), held});
    chk(d_res && d_ead == 8'hC2, "R9 second byte held", d_ead, 8'hC2);
    run(1'b1, 3'b000, 3'b000, 8'd2, 8'hD0, 8'h00);
    chk(nw == 2, "R9 plain send consumes holder", nw, 2);
    chk(sent[0] == {pat(8'hD0), pat(8'hC1)}, "R9 plain merged word", sent[0], {pat(8'hD0), pat(8'hC1)});
    chk(sent[1] == {8'h00, pat(8'hD1)}, "R7 single byte low lane", sent[1], {8'h00, pat(8'hD1)});
    chk(!d_res, "R7 plain leaves nothing held", int'(d_res), 0);

    if (!wd_fired) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule